// File: doc/BRIEF.md
# I2C Start/Stop Condition Generator

This block produces the START and STOP conditions of an I2C master by driving two open-drain pull-low enables, one for SDA and one for SCL. Software controls it through two trigger bits, a start request and a stop request. The surrounding register keeps each bit set until this block returns a one-cycle clear pulse for it. The block reads back the synchronized bus lines. It takes start and stop events from an external condition detector, where a start is SDA falling while SCL is high and a stop is SDA rising while SCL is high. It also takes an arbitration-lost flag from the byte engine.

The block keeps a bus-busy flag. The flag is set on every detected start and cleared on every detected stop. After reset, and whenever the interface is disabled, the flag reads busy, so the bus counts as not free until the first stop is seen. A start request made while the bus is busy is not lost. It stays pending as a reservation, and the start sequence begins by itself once the bus is released. A stop request is accepted in any state. When the block is not master, it first pulls SDA low and then completes a normal stop, which is how software frees the bus after enabling the interface.

The start hold time and the stop setup time are parameters counted in system clock cycles. A count only advances while SCL reads high, and it starts again from zero whenever another device holds SCL low.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset, and in every cycle after a cycle with `enable` low, `sda_pull`, `scl_pull` and `is_master` are 0 and `bus_busy` is 1.
- R2: `bus_busy` becomes 1 in the cycle after `start_det` and 0 in the cycle after `stop_det`. After enabling it stays 1 until the first `stop_det`.
- R3: With the bus free and `start_req` set, `sda_pull` rises first. After `HOLD_CYC` consecutive cycles with SCL high, `scl_pull` and `is_master` rise together, and `sda_pull` stays 1.
- R4: A `start_req` made while `bus_busy` is 1 and the block is not master pulls no line. The start sequence of R3 begins by itself once `bus_busy` falls.
- R5: A stop from master first holds SDA low while SCL is still pulled low. It then releases SCL. After `SETUP_CYC` consecutive cycles with SCL high it releases SDA, and `is_master` clears after the stop is detected.
- R6: A stop requested while not master pulls SDA low with SCL released, so SDA stays pulled for exactly `SETUP_CYC`+1 cycles with SCL high before it is released.
- R7: `start_clr` is 1 in the last hold cycle, at whose end master status is entered. `stop_clr` is 1 in every cycle in which `stop_det` is 1.
- R8: When `arb_lost` is 1, both `start_clr` and `stop_clr` are 1 in that cycle. From the next cycle `sda_pull`, `scl_pull` and `is_master` are 0, which also cancels a pending reservation.
- R9: If SCL is held low by another device during the hold or setup wait, the count restarts, and a full `HOLD_CYC` or `SETUP_CYC` of high cycles is needed after release.
- R10: When `start_req` and `stop_req` are both 1 in the idle state, the stop sequence is taken. A start still pending afterwards then runs as a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Interface enable; low forces idle and busy |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| start_req | input | 1 | Start trigger bit |
| stop_req | input | 1 | Stop trigger bit |
| start_det | input | 1 | One-cycle start-condition event from the detector |
| stop_det | input | 1 | One-cycle stop-condition event from the detector |
| arb_lost | input | 1 | Arbitration lost flag |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_pull | output | 1 | Pull SCL low when 1 |
| bus_busy | output | 1 | Bus is occupied (not free) |
| is_master | output | 1 | Block currently owns the bus |
| start_clr | output | 1 | Clear pulse for the start trigger bit |
| stop_clr | output | 1 | Clear pulse for the stop trigger bit |

## Verification
The hardest case is the clock-stretch restart of R9. It only shows up when another device pulls SCL low partway through the hold window, after SDA has already fallen and before SCL is pulled. The bench models the bus as a wired-AND of the design's pulls and an external device. It lets the start begin, pulls SCL low from the external side for a few cycles in the middle of the hold, and then expects exactly `HOLD_CYC` high cycles before `scl_pull` rises. The reservation of R4 is reached in a similar way: the external device opens a transfer, the request waits while the bus is busy, and the external stop must release it.

// File: rtl/i2c_cond_pkg.sv
// Package i2c_cond_pkg
// Shared types for the start/stop condition generator.
package i2c_cond_pkg;

    // Sequencer states: idle, start hold, owning the bus, and the three stop phases
    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_HOLD    = 3'd1,
        SEQ_OWN     = 3'd2,
        SEQ_SP_LOW  = 3'd3,
        SEQ_SP_SCL  = 3'd4,
        SEQ_SP_WAIT = 3'd5
    } seq_state_e;

endpackage

// File: rtl/cond_timer.sv
// Module cond_timer
// Counts consecutive clock cycles in which SCL reads high while the caller
// keeps `run` asserted. `done` is high in the LIMIT-th such cycle.
// Assumes LIMIT >= 1. A low SCL, or a dropped `run`, restarts the count at zero.
module cond_timer #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic scl_high,
    output logic done
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && scl_high && (cnt == CNT_W'(LIMIT - 1));

    // Advance while SCL is high, restart on stretch or when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !scl_high) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cond_busy.sv
// Module cond_busy
// Tracks whether the bus is occupied, using detected start/stop events.
// Assumes the events are one-cycle pulses from an external detector.
// Reads busy after reset and while disabled, until the first stop is seen.
module cond_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_det,
    input  logic stop_det,
    output logic bus_busy
);

    // Busy flag: forced while disabled, set on start, cleared on stop
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bus_busy <= 1'b1;
        end else if (start_det) begin
            bus_busy <= 1'b1;
        end else if (stop_det) begin
            bus_busy <= 1'b0;
        end
    end

    assert_disabled_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> bus_busy);

    assert_stop_frees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det && !start_det) |=> !bus_busy);

endmodule

// File: rtl/cond_seq.sv
// Module cond_seq
// Sequencer for the start and stop conditions. It decides which line to pull
// in each phase, tracks master status and makes the trigger clear pulses.
// Assumes the timers report completion through hold_done and setup_done.
module cond_seq
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_req,
    input  logic stop_req,
    input  logic bus_busy,
    input  logic stop_det,
    input  logic arb_lost,
    input  logic hold_done,
    input  logic setup_done,
    output logic hold_run,
    output logic setup_run,
    output logic sda_pull,
    output logic scl_pull,
    output logic is_master,
    output logic start_clr,
    output logic stop_clr
);

    seq_state_e state, state_nx;
    logic       master_nx;

    // Next-state selection; a stop request outranks a start request
    always_comb begin
        state_nx  = state;
        master_nx = is_master;
        if (!enable || arb_lost) begin
            state_nx  = SEQ_IDLE;
            master_nx = 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (stop_req) begin
                        state_nx = SEQ_SP_LOW;
                    end else if (start_req && !bus_busy) begin
                        state_nx = SEQ_HOLD;
                    end
                end
                SEQ_HOLD: begin
                    if (hold_done) begin
                        state_nx  = SEQ_OWN;
                        master_nx = 1'b1;
                    end
                end
                SEQ_OWN: begin
                    if (stop_req) begin
                        state_nx = SEQ_SP_LOW;
                    end
                end
                SEQ_SP_LOW: begin
                    if (!sda_in) begin
                        state_nx = SEQ_SP_SCL;
                    end
                end
                SEQ_SP_SCL: begin
                    if (setup_done) begin
                        state_nx = SEQ_SP_WAIT;
                    end
                end
                SEQ_SP_WAIT: begin
                    if (stop_det) begin
                        state_nx  = SEQ_IDLE;
                        master_nx = 1'b0;
                    end
                end
                default: begin
                    state_nx  = SEQ_IDLE;
                    master_nx = 1'b0;
                end
            endcase
        end
    end

    // State and master status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            is_master <= 1'b0;
        end else begin
            state     <= state_nx;
            is_master <= master_nx;
        end
    end

    // Line drive decode: SDA low from hold through stop setup, SCL low while owning
    always_comb begin
        sda_pull  = (state == SEQ_HOLD) || (state == SEQ_OWN) ||
                    (state == SEQ_SP_LOW) || (state == SEQ_SP_SCL);
        scl_pull  = (state == SEQ_OWN) || ((state == SEQ_SP_LOW) && is_master);
        hold_run  = (state == SEQ_HOLD);
        setup_run = (state == SEQ_SP_SCL);
    end

    // Trigger clear pulses
    always_comb begin
        start_clr = arb_lost || (enable && hold_run && hold_done);
        stop_clr  = arb_lost || stop_det;
    end

    assert_scl_after_sda_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(sda_pull));

    assert_master_from_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_master) |-> ($past(state) == SEQ_HOLD) && scl_pull);

    assert_sda_release_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull) && $past(enable) && !$past(arb_lost)) |-> $past(scl_in));

    assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |=> (!sda_pull && !scl_pull && !is_master));

    assert_stop_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && enable && !arb_lost && start_req && stop_req)
        |=> (state == SEQ_SP_LOW));

endmodule

// File: rtl/i2c_cond_gen.sv
// Module i2c_cond_gen
// Top of the I2C start/stop condition generator. It joins the busy tracker,
// the sequencer and the two timers (start hold and stop setup).
// Assumes synchronized bus inputs and one-cycle detector events.
module i2c_cond_gen #(
    parameter int HOLD_CYC  = 5,
    parameter int SETUP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_in,
    input  logic sda_in,
    input  logic start_req,
    input  logic stop_req,
    input  logic start_det,
    input  logic stop_det,
    input  logic arb_lost,
    output logic sda_pull,
    output logic scl_pull,
    output logic bus_busy,
    output logic is_master,
    output logic start_clr,
    output logic stop_clr
);

    logic hold_run, setup_run, hold_done, setup_done;

    cond_busy u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_busy  (bus_busy)
    );

    cond_timer #(.LIMIT(HOLD_CYC)) u_hold_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (hold_run),
        .scl_high (scl_in),
        .done     (hold_done)
    );

    cond_timer #(.LIMIT(SETUP_CYC)) u_setup_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (setup_run),
        .scl_high (scl_in),
        .done     (setup_done)
    );

    cond_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .bus_busy   (bus_busy),
        .stop_det   (stop_det),
        .arb_lost   (arb_lost),
        .hold_done  (hold_done),
        .setup_done (setup_done),
        .hold_run   (hold_run),
        .setup_run  (setup_run),
        .sda_pull   (sda_pull),
        .scl_pull   (scl_pull),
        .is_master  (is_master),
        .start_clr  (start_clr),
        .stop_clr   (stop_clr)
    );

    assert_pulls_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sda_pull && !scl_pull && !is_master));

endmodule

// File: tb/tb_i2c_cond_gen.sv
// Scoreboard bench: the stimulus pushes expected line events into a queue;
// a monitor pops them when the design's pulls change and compares counts.
module tb_i2c_cond_gen;
    localparam int H = 5;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic ext_sda = 1'b0, ext_scl = 1'b0, arb_lost = 1'b0;
    logic wr_start_set = 1'b0, wr_start_clr = 1'b0, wr_stop_set = 1'b0;
    logic start_req, stop_req;
    logic start_det, stop_det, sda_q;
    logic sda_pull, scl_pull, bus_busy, is_master, start_clr, stop_clr;
    logic sda_line, scl_line;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        int    kind;   // 1: scl_pull rose, 2: sda_pull fell
        int    val;    // SCL-high cycles seen with SDA pulled; -1 = any
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    assign sda_line = !(sda_pull || ext_sda);
    assign scl_line = !(scl_pull || ext_scl);

    i2c_cond_gen #(.HOLD_CYC(H), .SETUP_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .scl_in(scl_line), .sda_in(sda_line),
        .start_req(start_req), .stop_req(stop_req),
        .start_det(start_det), .stop_det(stop_det), .arb_lost(arb_lost),
        .sda_pull(sda_pull), .scl_pull(scl_pull), .bus_busy(bus_busy),
        .is_master(is_master), .start_clr(start_clr), .stop_clr(stop_clr)
    );

    // Bus condition detector (environment)
    always @(posedge clk) begin
        if (!rst_n) begin
            sda_q <= 1'b1; start_det <= 1'b0; stop_det <= 1'b0;
        end else begin
            sda_q     <= sda_line;
            start_det <= sda_q && !sda_line && scl_line;
            stop_det  <= !sda_q && sda_line && scl_line;
        end
    end

    // Trigger bit register model: software writes and self-clear pulses
    always @(posedge clk) begin
        if (!rst_n) begin
            start_req <= 1'b0; stop_req <= 1'b0;
        end else begin
            if (wr_start_set) start_req <= 1'b1;
            if (wr_start_clr || start_clr) start_req <= 1'b0;
            if (wr_stop_set) stop_req <= 1'b1;
            if (stop_clr) stop_req <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input int val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic pulse_start;
        wr_start_set = 1'b1; tick(1); wr_start_set = 1'b0;
    endtask

    task automatic pulse_stop;
        wr_stop_set = 1'b1; tick(1); wr_stop_set = 1'b0;
    endtask

    // Monitor: pops expectations on pull edges, sampled after each negedge
    int  run_cnt = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (!prev_scl && scl_pull) compare(1, run_cnt);
            if (prev_sda && !sda_pull) compare(2, run_cnt);
            if (scl_line && sda_pull && !scl_pull) run_cnt++;
            else run_cnt = 0;
        end
        prev_scl = scl_pull;
        prev_sda = sda_pull;
    end

    task automatic compare(input int kind, input int val);
        exp_t e;
        if (sb_q.size() == 0) begin
            chk(1'b0, "unexpected line event", kind, 0);
        end else begin
            e = sb_q.pop_front();
            chk(e.kind == kind, e.req, kind, e.kind);
            if (e.val >= 0) chk(e.val == val, e.req, val, e.val);
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2); #1;
        // R1: reset state
        chk(!sda_pull && !scl_pull, "R1 pulls", {sda_pull, scl_pull}, 0);
        chk(bus_busy == 1'b1, "R1 busy", bus_busy, 1);
        chk(is_master == 1'b0, "R1 master", is_master, 0);

        // R2/R4: bus not free after enabling, start is only reserved
        pulse_start(); tick(12); #1;
        chk(sda_pull == 1'b0, "R2 no start before first stop", sda_pull, 0);
        chk(start_req == 1'b1, "R4 request kept pending", start_req, 1);
        wr_start_clr = 1'b1; tick(1); wr_start_clr = 1'b0; tick(1);

        // R6: early stop when not master
        push(2, S + 1, "R6");
        pulse_stop(); tick(20); #1;
        chk(bus_busy == 1'b0, "R2 busy cleared by stop", bus_busy, 0);
        chk(stop_req == 1'b0, "R7 stop bit cleared", stop_req, 0);
        chk(is_master == 1'b0, "R6 not master", is_master, 0);

        // R3: start on a free bus
        push(1, H, "R3");
        pulse_start(); tick(20); #1;
        chk(is_master == 1'b1, "R3 master", is_master, 1);
        chk(start_req == 1'b0, "R7 start bit cleared", start_req, 0);
        chk(scl_pull && sda_pull, "R3 both pulled", {sda_pull, scl_pull}, 3);
        chk(bus_busy == 1'b1, "R2 busy after start", bus_busy, 1);

        // R5: stop from master
        push(2, S, "R5");
        pulse_stop(); tick(20); #1;
        chk(is_master == 1'b0, "R5 master cleared", is_master, 0);
        chk(bus_busy == 1'b0, "R5 bus free", bus_busy, 0);

        // R4: reservation while another master owns the bus
        ext_sda = 1'b1; tick(3); ext_scl = 1'b1; tick(2); #1;
        chk(bus_busy == 1'b1, "R2 busy from foreign start", bus_busy, 1);
        pulse_start(); tick(10); #1;
        chk(!sda_pull && !scl_pull, "R4 no pull while busy", {sda_pull, scl_pull}, 0);
        push(1, H, "R4");
        ext_scl = 1'b0; tick(2); ext_sda = 1'b0; tick(25); #1;
        chk(is_master == 1'b1, "R4 reserved start ran", is_master, 1);
        push(2, S, "R5");
        pulse_stop(); tick(20);

        // R9: SCL stretched during the hold window
        push(1, H, "R9");
        pulse_start(); tick(2);
        ext_scl = 1'b1; tick(4); ext_scl = 1'b0; tick(20); #1;
        chk(is_master == 1'b1, "R9 master after stretch", is_master, 1);

        // R8: arbitration lost while master
        push(2, -1, "R8");
        arb_lost = 1'b1; tick(1); arb_lost = 1'b0; #1;
        chk(!sda_pull && !scl_pull, "R8 lines released", {sda_pull, scl_pull}, 0);
        chk(is_master == 1'b0, "R8 master cleared", is_master, 0);
        tick(5);

        // R8: arbitration loss cancels a reservation
        ext_sda = 1'b1; tick(3);
        pulse_start(); tick(3);
        arb_lost = 1'b1; tick(1); arb_lost = 1'b0; tick(2); #1;
        chk(start_req == 1'b0, "R8 reservation cleared", start_req, 0);
        ext_sda = 1'b0; tick(12); #1;
        chk(sda_pull == 1'b0, "R8 no start after cancel", sda_pull, 0);

        // R10: both triggers together, stop wins then start runs
        push(2, S + 1, "R10");
        push(1, H, "R10");
        wr_start_set = 1'b1; wr_stop_set = 1'b1; tick(1);
        wr_start_set = 1'b0; wr_stop_set = 1'b0;
        tick(40); #1;
        chk(is_master == 1'b1, "R10 start after stop", is_master, 1);
        push(2, S, "R5");
        pulse_stop(); tick(20);

        // R1/R2: disable forces busy and stays busy after re-enable
        enable = 1'b0; tick(3); #1;
        chk(bus_busy == 1'b1, "R1 busy when disabled", bus_busy, 1);
        chk(!sda_pull && !scl_pull, "R1 pulls when disabled", {sda_pull, scl_pull}, 0);
        enable = 1'b1; tick(3); #1;
        chk(bus_busy == 1'b1, "R2 busy after re-enable", bus_busy, 1);

        tick(2);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule